// File: doc/BRIEF.md
# Phase Accumulator and Phase Argument Generator

This block is the phase engine of a numerically controlled oscillator. Software programs three control words through a 16-bit write port: a phase word, a frequency offset word and a center frequency word. Each control word is copied into its working register on a clock-domain enable. On every enabled clock, the 32-bit phase accumulator advances by the center frequency plus the frequency offset. The top 16 bits of the accumulator, plus the phase register, form the argument that a sine/cosine lookup downstream consumes.

The offset can be removed from the frequency sum without erasing it. The accumulator can be restarted from the current increment, and it can be bumped by one extra count. Quadrature phase steps can be forced from two modulation pins instead of the programmed phase word. The argument can also be confined to half a cycle. Every control pin is sampled on the clock before it acts. An active-low flag reports each accumulator wrap.

Top module: `nco_pfc`

## Requirements
- R1: A synchronous active-high reset clears every register. After the reset edge, the argument is 0 and the wrap flag is 1.
- R2: Write port. A write occurs at a clock edge that samples the write strobe high when it was low at the previous edge, with the select low. A strobe held high writes only once, and nothing is written while the select is high. Address 0 loads the phase word. Address 1 loads offset bits 15:0 and address 2 loads offset bits 31:16. Address 3 shifts the data into bits 31:16 of the center word and moves the old bits 31:16 down to bits 15:0, so the center word is written low half first, then high half.
- R3: The active-low enables for the phase, offset, center and accumulator registers are sampled at one edge and act at the next edge. A register whose enable was sampled high keeps its value.
- R4: At each accumulator step, the accumulator gains the frequency increment: center + offset, modulo 2^32.
- R5: The active-low offset clear, registered like the enables, removes the offset from the increment. The stored offset is unchanged, and it can still be written and loaded while the clear is active.
- R6: The active-low load control, registered, zeroes the accumulator feedback. A step then leaves the accumulator equal to the increment (plus any carry-in).
- R7: The active-low carry-in, registered, adds one to the accumulator at each step it coincides with.
- R8: The wrap flag is 0 for one cycle after each step whose 33-bit sum exceeds 2^32-1, and 1 at all other times.
- R9: When the registered phase-source control is high, the phase register loads the phase word. When it is low, the register loads a quadrature step from the two modulation pins: code 00 gives 0 degrees (0x0000), 01 gives 90 degrees (0x4000), 10 gives 270 degrees (0xC000), and 11 gives 180 degrees (0x8000).
- R10: The argument is accumulator bits 31:16 plus the phase register, modulo 2^16.
- R11: When the registered half-cycle control is high, argument bit 15 is forced to 0. This takes effect right after the edge that samples the control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgData | input | 16 | Write data |
| cfgAddr | input | 2 | Write address |
| cfgSelN | input | 1 | Write select, active low |
| cfgWr | input | 1 | Write strobe, acts on its rising transition |
| phaseEnN | input | 1 | Phase register enable, active low |
| offsetEnN | input | 1 | Offset register enable, active low |
| centerEnN | input | 1 | Center register enable, active low |
| accEnN | input | 1 | Accumulator step enable, active low |
| offsetClrN | input | 1 | Removes offset from increment, active low |
| accLoadN | input | 1 | Zeroes accumulator feedback, active low |
| carryInN | input | 1 | Extra count into accumulator, active low |
| phaseSrcSel | input | 1 | 1: phase word, 0: modulation pins |
| modCode | input | 2 | Quadrature step code |
| halfCycle | input | 1 | Forces argument MSB to zero |
| phaseArg | output | 16 | Phase argument |
| wrapN | output | 1 | Accumulator wrap flag, active low |

## Verification
The load, carry-in and offset-clear controls can all act on the same accumulator step. The bench sweeps all eight combinations of the three, holding each combination for several steps. The case where load and carry-in coincide with a near-full center word is judged by whether the lone extra count produces a wrap. A second collision is a write to the offset word while the offset clear is held. For that case, the bench checks that the argument keeps advancing by the center word alone, and that the new offset appears once the clear is released. In every cycle, a cycle-accurate arithmetic model in the bench predicts the argument and the wrap flag.

// File: rtl/nco_pfc_pkg.sv
package nco_pfc_pkg;
  typedef struct packed {
    logic       phaseLd;
    logic       offsetLd;
    logic       centerLd;
    logic       accStep;
    logic       offsetClr;
    logic       accLoad;
    logic       carryIn;
    logic       phaseFromCtl;
    logic [1:0] modTop;
    logic       halfCycle;
  } pfcStrobes_t;
endpackage

// File: rtl/nco_pfc_ctrl.sv
module nco_pfc_ctrl
  import nco_pfc_pkg::*;
#(
  parameter int BUS_W = 16,
  localparam int ACC_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  cfgData,
  input  logic [1:0]        cfgAddr,
  input  logic              cfgSelN,
  input  logic              cfgWr,
  input  logic              phaseEnN,
  input  logic              offsetEnN,
  input  logic              centerEnN,
  input  logic              accEnN,
  input  logic              offsetClrN,
  input  logic              accLoadN,
  input  logic              carryInN,
  input  logic              phaseSrcSel,
  input  logic [1:0]        modCode,
  input  logic              halfCycle,
  output pfcStrobes_t       strb,
  output logic [BUS_W-1:0]  phaseCtl,
  output logic [ACC_W-1:0]  offsetCtl,
  output logic [ACC_W-1:0]  centerCtl
);
  logic wrPrev;
  logic wrEdge;

  // a write needs a low-to-high strobe transition seen by clk
  assign wrEdge = cfgWr & ~wrPrev & ~cfgSelN;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPrev    <= 1'b0;
      phaseCtl  <= '0;
      offsetCtl <= '0;
      centerCtl <= '0;
    end else begin
      wrPrev <= cfgWr;
      if (wrEdge) begin
        unique case (cfgAddr)
          2'd0: phaseCtl <= cfgData;
          2'd1: offsetCtl[BUS_W-1:0] <= cfgData;
          2'd2: offsetCtl[ACC_W-1:BUS_W] <= cfgData;
          2'd3: centerCtl <= {cfgData, centerCtl[ACC_W-1:BUS_W]};
          default: ;
        endcase
      end
    end
  end

  // every control pin passes one clk register before it acts
  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= '0;
    end else begin
      strb.phaseLd      <= ~phaseEnN;
      strb.offsetLd     <= ~offsetEnN;
      strb.centerLd     <= ~centerEnN;
      strb.accStep      <= ~accEnN;
      strb.offsetClr    <= ~offsetClrN;
      strb.accLoad      <= ~accLoadN;
      strb.carryIn      <= ~carryInN;
      strb.phaseFromCtl <= phaseSrcSel;
      // quadrature code to top two phase bits: 00->00 01->01 10->11 11->10
      strb.modTop       <= {modCode[1], modCode[1] ^ modCode[0]};
      strb.halfCycle    <= halfCycle;
    end
  end
endmodule

// File: rtl/nco_pfc_path.sv
module nco_pfc_path
  import nco_pfc_pkg::*;
#(
  parameter int BUS_W = 16,
  localparam int ACC_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  pfcStrobes_t       strb,
  input  logic [BUS_W-1:0]  phaseCtl,
  input  logic [ACC_W-1:0]  offsetCtl,
  input  logic [ACC_W-1:0]  centerCtl,
  output logic [BUS_W-1:0]  phaseArg,
  output logic              wrapN,
  output logic [ACC_W-1:0]  accVal,
  output logic [ACC_W-1:0]  offsetVal
);
  logic [BUS_W-1:0] phaseReg;
  logic [ACC_W-1:0] offsetReg;
  logic [ACC_W-1:0] centerReg;
  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] freqInc;
  logic [ACC_W-1:0] feedback;
  logic [ACC_W:0]   stepSum;
  logic [BUS_W-1:0] argSum;
  logic [BUS_W-1:0] modPhase;

  assign freqInc  = centerReg + (strb.offsetClr ? '0 : offsetReg);
  assign feedback = strb.accLoad ? '0 : accReg;
  assign stepSum  = {1'b0, feedback} + {1'b0, freqInc} + (ACC_W+1)'(strb.carryIn);
  assign modPhase = {strb.modTop, {(BUS_W-2){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseReg  <= '0;
      offsetReg <= '0;
      centerReg <= '0;
      accReg    <= '0;
      wrapN     <= 1'b1;
    end else begin
      if (strb.phaseLd)  phaseReg  <= strb.phaseFromCtl ? phaseCtl : modPhase;
      if (strb.offsetLd) offsetReg <= offsetCtl;
      if (strb.centerLd) centerReg <= centerCtl;
      if (strb.accStep)  accReg    <= stepSum[ACC_W-1:0];
      wrapN <= ~(strb.accStep & stepSum[ACC_W]);
    end
  end

  assign argSum    = accReg[ACC_W-1 -: BUS_W] + phaseReg;
  assign phaseArg  = strb.halfCycle ? {1'b0, argSum[BUS_W-2:0]} : argSum;
  assign accVal    = accReg;
  assign offsetVal = offsetReg;
endmodule

// File: rtl/nco_pfc.sv
module nco_pfc
  import nco_pfc_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  cfgData,
  input  logic [1:0]        cfgAddr,
  input  logic              cfgSelN,
  input  logic              cfgWr,
  input  logic              phaseEnN,
  input  logic              offsetEnN,
  input  logic              centerEnN,
  input  logic              accEnN,
  input  logic              offsetClrN,
  input  logic              accLoadN,
  input  logic              carryInN,
  input  logic              phaseSrcSel,
  input  logic [1:0]        modCode,
  input  logic              halfCycle,
  output logic [BUS_W-1:0]  phaseArg,
  output logic              wrapN
);
  localparam int ACC_W = 2 * BUS_W;

  pfcStrobes_t      strb;
  logic [BUS_W-1:0] phaseCtl;
  logic [ACC_W-1:0] offsetCtl;
  logic [ACC_W-1:0] centerCtl;
  logic [ACC_W-1:0] accVal;
  logic [ACC_W-1:0] offsetVal;

  nco_pfc_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfgData(cfgData), .cfgAddr(cfgAddr),
    .cfgSelN(cfgSelN), .cfgWr(cfgWr), .phaseEnN(phaseEnN),
    .offsetEnN(offsetEnN), .centerEnN(centerEnN), .accEnN(accEnN),
    .offsetClrN(offsetClrN), .accLoadN(accLoadN), .carryInN(carryInN),
    .phaseSrcSel(phaseSrcSel), .modCode(modCode), .halfCycle(halfCycle),
    .strb(strb), .phaseCtl(phaseCtl), .offsetCtl(offsetCtl),
    .centerCtl(centerCtl)
  );

  nco_pfc_path #(.BUS_W(BUS_W)) u_path (
    .clk(clk), .rst(rst), .strb(strb), .phaseCtl(phaseCtl),
    .offsetCtl(offsetCtl), .centerCtl(centerCtl), .phaseArg(phaseArg),
    .wrapN(wrapN), .accVal(accVal), .offsetVal(offsetVal)
  );
endmodule

// File: rtl/nco_pfc_chk.sv
module nco_pfc_chk #(
  parameter int BUS_W = 16,
  localparam int ACC_W = 2 * BUS_W
) (
  input logic             clk,
  input logic             rst,
  input logic             accEnN,
  input logic             offsetEnN,
  input logic             halfCycle,
  input logic             wrapN,
  input logic [BUS_W-1:0] phaseArg,
  input logic [ACC_W-1:0] accVal,
  input logic [ACC_W-1:0] offsetVal
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (wrapN && phaseArg == '0));

  p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && $past(accEnN, 2)) |-> $stable(accVal));

  p_offset_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && $past(offsetEnN, 2)) |-> $stable(offsetVal));

  p_wrap_needs_step_r8: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && !wrapN) |-> !$past(accEnN, 2));

  p_half_msb_r11: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && $past(halfCycle)) |-> !phaseArg[BUS_W-1]);
endmodule

bind nco_pfc nco_pfc_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .accEnN(accEnN), .offsetEnN(offsetEnN),
  .halfCycle(halfCycle), .wrapN(wrapN), .phaseArg(phaseArg),
  .accVal(accVal), .offsetVal(offsetVal)
);

// File: tb/nco_pfc_test.sv
`timescale 1ns/1ps
module nco_pfc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfgData = '0;
  logic [1:0]  cfgAddr = '0;
  logic        cfgSelN = 1'b1, cfgWr = 1'b0;
  logic        phaseEnN = 1'b1, offsetEnN = 1'b1, centerEnN = 1'b1, accEnN = 1'b1;
  logic        offsetClrN = 1'b1, accLoadN = 1'b1, carryInN = 1'b1;
  logic        phaseSrcSel = 1'b1, halfCycle = 1'b0;
  logic [1:0]  modCode = '0;
  logic [15:0] phaseArg;
  logic        wrapN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nco_pfc uut (
    .clk(clk), .rst(rst), .cfgData(cfgData), .cfgAddr(cfgAddr),
    .cfgSelN(cfgSelN), .cfgWr(cfgWr), .phaseEnN(phaseEnN),
    .offsetEnN(offsetEnN), .centerEnN(centerEnN), .accEnN(accEnN),
    .offsetClrN(offsetClrN), .accLoadN(accLoadN), .carryInN(carryInN),
    .phaseSrcSel(phaseSrcSel), .modCode(modCode), .halfCycle(halfCycle),
    .phaseArg(phaseArg), .wrapN(wrapN)
  );

  // reference model built from the requirements
  logic [15:0] mPhCtl, mPh;
  logic [31:0] mOffCtl, mCenCtl, mOff, mCen, mAcc;
  logic        mWrPrev, mWrapN;
  logic        qPh, qOff, qCen, qAcc, qClr, qLoad, qCarry, qSel, qHalf;
  logic [1:0]  qMod;
  logic [31:0] mInc;
  logic [32:0] mNext;

  function automatic int modDegrees(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 90;
      2'd2: return 270;
      default: return 180;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhCtl = '0; mOffCtl = '0; mCenCtl = '0; mPh = '0; mOff = '0; mCen = '0;
      mAcc = '0; mWrPrev = 0; mWrapN = 1;
      {qPh, qOff, qCen, qAcc, qClr, qLoad, qCarry, qSel, qHalf} = '0;
      qMod = '0;
    end else begin
      mInc  = mCen + (qClr ? 32'd0 : mOff);
      mNext = {1'b0, (qLoad ? 32'd0 : mAcc)} + {1'b0, mInc} + {32'd0, qCarry};
      mWrapN = !(qAcc && mNext[32]);
      if (qAcc) mAcc = mNext[31:0];
      if (qPh) mPh = qSel ? mPhCtl : 16'((modDegrees(qMod) * 65536) / 360);
      if (qOff) mOff = mOffCtl;
      if (qCen) mCen = mCenCtl;
      if (cfgWr && !mWrPrev && !cfgSelN) begin
        case (cfgAddr)
          2'd0: mPhCtl = cfgData;
          2'd1: mOffCtl = {mOffCtl[31:16], cfgData};
          2'd2: mOffCtl = {cfgData, mOffCtl[15:0]};
          default: mCenCtl = {cfgData, mCenCtl[31:16]};
        endcase
      end
      mWrPrev = cfgWr;
      qPh = !phaseEnN; qOff = !offsetEnN; qCen = !centerEnN; qAcc = !accEnN;
      qClr = !offsetClrN; qLoad = !accLoadN; qCarry = !carryInN;
      qSel = phaseSrcSel; qHalf = halfCycle; qMod = modCode;
    end
  end

  function automatic logic [15:0] expArg();
    logic [15:0] a;
    a = mAcc[31:16] + mPh;
    if (qHalf) a[15] = 1'b0;
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " arg"}, 32'(phaseArg), 32'(expArg()));
    chk({tag, " wrap"}, 32'(wrapN), 32'(mWrapN));
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
    cfgAddr = a; cfgData = d; cfgSelN = 0; cfgWr = 1;
    cyc(tag);
    cfgWr = 0; cfgSelN = 1;
    cyc(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [15:0] a0;
    int wraps;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset arg", 32'(phaseArg), 32'd0);
    chk("R1 reset wrap", 32'(wrapN), 32'd1);
    rst = 0;

    // R2 center in two halves, R3 delayed enable, R4 stepping
    wr(2'd3, 16'h0000, "R2");
    wr(2'd3, 16'h0001, "R2");
    centerEnN = 0; cyc("R3"); centerEnN = 1;
    accEnN = 0;
    repeat (4) cyc("R4");
    a0 = phaseArg; cyc("R4");
    chk("R4 unit step", 32'(phaseArg), 32'(16'(a0 + 16'd1)));

    wr(2'd1, 16'h8000, "R2");
    wr(2'd2, 16'h0001, "R2");
    offsetEnN = 0; cyc("R3"); offsetEnN = 1;
    repeat (6) cyc("R4");

    // sweep of increments, many of them wrapping often
    for (int k = 0; k < 12; k++) begin
      wr(2'd3, 16'(k * 16'h1357), "R2");
      wr(2'd3, 16'(16'h1000 << (k % 4)) | 16'(k), "R2");
      wr(2'd1, 16'(k * 16'h0F0F), "R2");
      wr(2'd2, 16'(k * 16'h0C00), "R2");
      centerEnN = 0; offsetEnN = 0; cyc("R3"); centerEnN = 1; offsetEnN = 1;
      repeat (20) cyc("R4 R8");
    end

    // R3 hold: stop stepping and watch the argument stay put
    accEnN = 1; cyc("R3");
    a0 = phaseArg;
    repeat (3) cyc("R3");
    chk("R3 hold", 32'(phaseArg), 32'(a0));

    // R2 ignored writes: select high, then strobe held high
    cfgAddr = 2'd0; cfgData = 16'h1234; cfgSelN = 1; cfgWr = 1; cyc("R2");
    cfgWr = 0; cyc("R2");
    phaseEnN = 0; phaseSrcSel = 1; repeat (3) cyc("R2"); phaseEnN = 1;
    chk("R2 select high ignored", 32'(phaseArg), 32'(a0));
    cfgSelN = 0; cfgWr = 1; cfgData = 16'h0100; cyc("R2");
    cfgData = 16'h0777; cyc("R2");
    cfgWr = 0; cfgSelN = 1; cyc("R2");
    phaseEnN = 0; repeat (3) cyc("R2"); phaseEnN = 1; cyc("R2");
    chk("R2 single write on held strobe", 32'(phaseArg), 32'(16'(a0 + 16'h0100)));

    // clear accumulator via load with zero increment, then quadrature sweep
    wr(2'd3, 16'h0000, "R6"); wr(2'd3, 16'h0000, "R6");
    centerEnN = 0; offsetClrN = 0; cyc("R6"); centerEnN = 1;
    accLoadN = 0; accEnN = 0; repeat (3) cyc("R6");
    accEnN = 1; accLoadN = 1; offsetClrN = 1; repeat (2) cyc("R6");
    phaseSrcSel = 0; phaseEnN = 0;
    for (int m = 0; m < 4; m++) begin
      modCode = 2'(m);
      cyc("R9"); cyc("R9");
      chk("R9 quadrature step", 32'(phaseArg), 32'((modDegrees(2'(m)) * 65536) / 360));
      halfCycle = 1; cyc("R11");
      chk("R11 half cycle", 32'(phaseArg), 32'(((modDegrees(2'(m)) * 65536) / 360) & 16'h7FFF));
      halfCycle = 0; cyc("R11");
    end
    phaseEnN = 1; phaseSrcSel = 1;

    // R5 R6 R7 all combinations, including same-cycle collisions
    wr(2'd3, 16'h0000, "R5"); wr(2'd3, 16'h0001, "R5");
    wr(2'd1, 16'h0000, "R5"); wr(2'd2, 16'h0002, "R5");
    centerEnN = 0; offsetEnN = 0; cyc("R5"); centerEnN = 1; offsetEnN = 1;
    accEnN = 0;
    for (int c = 0; c < 8; c++) begin
      offsetClrN = c[0]; accLoadN = c[1]; carryInN = c[2];
      repeat (4) cyc("R5 R6 R7 R10");
    end
    offsetClrN = 1; accLoadN = 1; carryInN = 1;

    // R5 write offset while cleared
    offsetClrN = 0;
    wr(2'd2, 16'h0005, "R5");
    offsetEnN = 0; cyc("R5"); offsetEnN = 1;
    repeat (3) cyc("R5");
    a0 = phaseArg; cyc("R5");
    chk("R5 clear keeps center only", 32'(phaseArg), 32'(16'(a0 + 16'd1)));
    offsetClrN = 1; repeat (2) cyc("R5");
    a0 = phaseArg; cyc("R5");
    chk("R5 new offset used", 32'(phaseArg), 32'(16'(a0 + 16'd6)));

    // R6 R7 R8 load and carry with all-ones increment gives one wrap
    wr(2'd3, 16'hFFFF, "R8"); wr(2'd3, 16'hFFFF, "R8");
    wr(2'd2, 16'h0000, "R8");
    centerEnN = 0; offsetEnN = 0; cyc("R8"); centerEnN = 1; offsetEnN = 1;
    accLoadN = 0; carryInN = 0; cyc("R8"); cyc("R8");
    cyc("R8");
    chk("R8 load plus carry wraps", 32'(wrapN), 32'd0);
    chk("R6 R7 load plus carry result", 32'(phaseArg), 32'(expArg()));
    accLoadN = 1; carryInN = 1; repeat (3) cyc("R8");

    // R8 wrap rate: quarter-cycle increment wraps every fourth step
    wr(2'd3, 16'h0000, "R8"); wr(2'd3, 16'h4000, "R8");
    centerEnN = 0; cyc("R8"); centerEnN = 1; repeat (2) cyc("R8");
    wraps = 0;
    for (int i = 0; i < 16; i++) begin
      cyc("R8");
      if (!wrapN) wraps++;
    end
    chk("R8 wrap count", 32'(wraps), 32'd4);

    accEnN = 1;
    repeat (3) cyc("R10");
    finishRun();
  end
endmodule